// File: doc/BRIEF.md
# Host Domain Reset Controller

This block produces the reset qualifiers for the host side of a chip. Registers on that side fall into three classes, and each class has its own qualifier. Ordinary configuration registers use `sw_or_hw_rst`. Lock and write-protect bits use `hw_rst`. Battery-backed registers use `por_rst`.

A hardware reset starts from any of three sources:
- a power-on input;
- an active-low primary reset pin;
- an optional secondary reset pin.

A two-bit protection word routes the secondary reset to one of two candidate pins, or turns it off. When it is enabled, the chosen pin also serves as a general-purpose input. Each assertion of the secondary reset sets a sticky interrupt flag toward the core.

A software reset starts when software writes 1 to the command bit of the control register. The command bit then reads back as 1 until the pulse has finished, and then clears itself. Strap pins are latched once, when power-on reset is released, and keep that value through every later warm reset.

A small sequencer has three states:
- `ST_HOLD` is entered asynchronously while a hardware reset is asserted.
- `ST_HOLD` → `ST_RUN` on the first clock edge after the hardware reset is released.
- `ST_RUN` → `ST_SWP` on a command write.
- `ST_SWP` → `ST_RUN` when the pulse counter has counted the full pulse.
- Any state → `ST_HOLD` whenever a hardware reset asserts.

Top module: `host_rst_ctrl`

## Requirements
- R1: While `por_n` is low, `por_rst`, `hw_rst` and `sw_or_hw_rst` are all 1, and `reset2_irq` and `strap_q` are 0.
- R2: When `prim_rst_n` goes low, `hw_rst` and `sw_or_hw_rst` rise at once without waiting for a clock edge, and `por_rst` stays 0. After `prim_rst_n` rises, both stay high on the next falling clock edge and read 0 one clock later (two-stage release).
- R3: A write with `cfg_wr`=1 and `cfg_wdata` bit 1 = 1 while in `ST_RUN` drives `sw_or_hw_rst` high for exactly 4 clock cycles, starting right after the write edge. `hw_rst` and `por_rst` stay 0 during the pulse.
- R4: `cfg_rdata` bit 1 reads 1 for the whole software pulse and reads 0 after it ends.
- R5: Further command writes during a pulse are ignored: the pulse still ends 4 cycles after the first write.
- R6: Protection word encoding: `prot_sel`=2'b01 selects `alt_pin_a`, 2'b10 selects `alt_pin_b`, and 2'b00 or 2'b11 disables the secondary reset. The selected pin driven low asserts `hw_rst`. An unselected pin has no effect.
- R7: Each assertion of the enabled secondary reset sets `reset2_irq`, which also reads on `cfg_rdata` bit 4. A write with `cfg_wdata` bit 4 = 1 clears it. Hardware and software resets leave the flag unchanged; only power-on reset clears it.
- R8: `strap_q` takes `strap_in` on the first clock edge after `por_rst` deasserts. It then holds that value through hardware and software resets, whatever `strap_in` does.
- R9: `sec_gpio` shows the synchronised level of the selected candidate pin while the secondary reset is enabled, and reads 0 while it is disabled.
- R10: A hardware reset during a software pulse cancels the pulse. After the hardware reset is released, no pulse resumes and `cfg_rdata` bit 1 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host domain clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| prim_rst_n | input | 1 | Primary hardware reset pin, active low, asynchronous |
| alt_pin_a | input | 1 | First candidate pin for the secondary reset, active low |
| alt_pin_b | input | 1 | Second candidate pin for the secondary reset, active low |
| prot_sel | input | 2 | Protection word field that routes the secondary reset |
| strap_in | input | STRAP_W | Strap pin levels |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | CFG_W | Control register write data (bit 1 = command, bit 4 = clear interrupt) |
| cfg_rdata | output | CFG_W | Control register read data (bit 1 = pulse busy, bit 4 = interrupt flag) |
| hw_rst | output | 1 | Reset qualifier for lock and protect bits |
| sw_or_hw_rst | output | 1 | Reset qualifier for ordinary registers |
| por_rst | output | 1 | Reset qualifier for battery-backed registers |
| reset2_irq | output | 1 | Sticky secondary reset interrupt flag |
| sec_gpio | output | 1 | Selected pin seen as a general-purpose input |
| strap_q | output | STRAP_W | Latched strap configuration |

## Verification
The assertions check four things on every clock:
- the nesting of the qualifiers (power-on implies hardware, and hardware implies the ordinary-register qualifier);
- that a software-only pulse never lasts beyond its length;
- that the busy bit never falls while a software-only pulse continues;
- that the interrupt flag and the latched straps never change without a cause.

The bench scenarios show the following:
- the asynchronous assertion and two-stage release of the hardware reset;
- the pin routing under each protection code;
- that repeated writes are ignored;
- that a hardware reset cancels a pulse;
- that the interrupt flag and the straps survive warm resets and are cleared only by power-on reset.

// File: rtl/host_rst_pkg.sv
package host_rst_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_SWP  = 2'd2
    } seq_state_e;

    localparam int CMD_SWRST_BIT = 1;
    localparam int IRQ_BIT       = 4;

    localparam logic [1:0] SEL_PIN_A = 2'b01;
    localparam logic [1:0] SEL_PIN_B = 2'b10;

endpackage

// File: rtl/rst_sync_chain.sv
module rst_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_o
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            q <= '0;
        end else begin
            q <= {q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_o = ~q[STAGES-1];
endmodule

// File: rtl/sec_rst_sel.sv
module sec_rst_sel
    import host_rst_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       por_rst,
    input  logic [1:0] prot_sel,
    input  logic       pin_a,
    input  logic       pin_b,
    input  logic       clr_irq,
    output logic       sec_act_raw,
    output logic       gpio_val,
    output logic       irq
);
    logic              en;
    logic              pin_sel;
    logic [STAGES-1:0] sq;
    logic              act_prev;
    logic              act_sync;

    always_comb begin
        unique case (prot_sel)
            SEL_PIN_A: begin en = 1'b1; pin_sel = pin_a; end
            SEL_PIN_B: begin en = 1'b1; pin_sel = pin_b; end
            default:   begin en = 1'b0; pin_sel = 1'b1;  end
        endcase
    end

    assign sec_act_raw = en & ~pin_sel;

    always_ff @(posedge clk or posedge por_rst) begin
        if (por_rst) begin
            sq <= '1;
        end else begin
            sq <= {sq[STAGES-2:0], pin_sel};
        end
    end

    assign act_sync = ~sq[STAGES-1];
    assign gpio_val = en & sq[STAGES-1];

    always_ff @(posedge clk or posedge por_rst) begin
        if (por_rst) begin
            act_prev <= 1'b0;
            irq      <= 1'b0;
        end else begin
            act_prev <= act_sync;
            if (act_sync && !act_prev) begin
                irq <= 1'b1;
            end else if (clr_irq) begin
                irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/host_rst_seq.sv
module host_rst_seq
    import host_rst_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic hw_rst,
    input  logic cmd_wr,
    output logic sw_pulse,
    output logic cmd_busy
);
    localparam int CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

    seq_state_e    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or posedge hw_rst) begin
        if (hw_rst) begin
            state <= ST_HOLD;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_HOLD: begin
                state_nx = ST_RUN;
                cnt_nx   = '0;
            end
            ST_RUN: begin
                if (cmd_wr) begin
                    state_nx = ST_SWP;
                    cnt_nx   = '0;
                end
            end
            ST_SWP: begin
                if (cnt == LAST) begin
                    state_nx = ST_RUN;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                state_nx = ST_HOLD;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        sw_pulse = 1'b0;
        cmd_busy = 1'b0;
        unique case (state)
            ST_HOLD: begin sw_pulse = 1'b0; cmd_busy = 1'b0; end
            ST_RUN:  begin sw_pulse = 1'b0; cmd_busy = 1'b0; end
            ST_SWP:  begin sw_pulse = 1'b1; cmd_busy = 1'b1; end
            default: begin sw_pulse = 1'b0; cmd_busy = 1'b0; end
        endcase
    end
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
    parameter int STRAP_W = 4
) (
    input  logic               clk,
    input  logic               por_rst,
    input  logic [STRAP_W-1:0] strap_in,
    output logic [STRAP_W-1:0] strap_q
);
    logic taken;

    always_ff @(posedge clk or posedge por_rst) begin
        if (por_rst) begin
            taken   <= 1'b0;
            strap_q <= '0;
        end else if (!taken) begin
            taken   <= 1'b1;
            strap_q <= strap_in;
        end
    end
endmodule

// File: rtl/host_rst_ctrl.sv
module host_rst_ctrl
    import host_rst_pkg::*;
#(
    parameter int STRAP_W      = 4,
    parameter int CFG_W        = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int SW_PULSE_LEN = 4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               prim_rst_n,
    input  logic               alt_pin_a,
    input  logic               alt_pin_b,
    input  logic [1:0]         prot_sel,
    input  logic [STRAP_W-1:0] strap_in,
    input  logic               cfg_wr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    output logic               hw_rst,
    output logic               sw_or_hw_rst,
    output logic               por_rst,
    output logic               reset2_irq,
    output logic               sec_gpio,
    output logic [STRAP_W-1:0] strap_q
);
    logic sec_act_raw;
    logic hw_src_n;
    logic sw_pulse;
    logic cmd_busy;
    logic cmd_wr;
    logic clr_irq;

    assign cmd_wr  = cfg_wr & cfg_wdata[CMD_SWRST_BIT];
    assign clr_irq = cfg_wr & cfg_wdata[IRQ_BIT];

    rst_sync_chain #(.STAGES(SYNC_STAGES)) u_por_sync (
        .clk    (clk),
        .arst_n (por_n),
        .rst_o  (por_rst)
    );

    assign hw_src_n = por_n & prim_rst_n & ~sec_act_raw;

    rst_sync_chain #(.STAGES(SYNC_STAGES)) u_hw_sync (
        .clk    (clk),
        .arst_n (hw_src_n),
        .rst_o  (hw_rst)
    );

    sec_rst_sel #(.STAGES(SYNC_STAGES)) u_sec (
        .clk         (clk),
        .por_rst     (por_rst),
        .prot_sel    (prot_sel),
        .pin_a       (alt_pin_a),
        .pin_b       (alt_pin_b),
        .clr_irq     (clr_irq),
        .sec_act_raw (sec_act_raw),
        .gpio_val    (sec_gpio),
        .irq         (reset2_irq)
    );

    host_rst_seq #(.PULSE_LEN(SW_PULSE_LEN)) u_seq (
        .clk      (clk),
        .hw_rst   (hw_rst),
        .cmd_wr   (cmd_wr),
        .sw_pulse (sw_pulse),
        .cmd_busy (cmd_busy)
    );

    strap_latch #(.STRAP_W(STRAP_W)) u_strap (
        .clk      (clk),
        .por_rst  (por_rst),
        .strap_in (strap_in),
        .strap_q  (strap_q)
    );

    assign sw_or_hw_rst = hw_rst | sw_pulse;

    always_comb begin
        cfg_rdata                = '0;
        cfg_rdata[CMD_SWRST_BIT] = cmd_busy;
        cfg_rdata[IRQ_BIT]       = reset2_irq;
    end
endmodule

// File: rtl/host_rst_ctrl_chk.sv
module host_rst_ctrl_chk #(
    parameter int PULSE_LEN = 4,
    parameter int STRAP_W   = 4,
    parameter int CFG_W     = 8
) (
    input logic               clk,
    input logic               por_n,
    input logic               cfg_wr,
    input logic [CFG_W-1:0]   cfg_wdata,
    input logic [CFG_W-1:0]   cfg_rdata,
    input logic               hw_rst,
    input logic               sw_or_hw_rst,
    input logic               por_rst,
    input logic               reset2_irq,
    input logic [STRAP_W-1:0] strap_q
);
    localparam int PW = $clog2(PULSE_LEN + 1) + 1;

    logic [PW-1:0] sw_cnt;
    logic [1:0]    since_por;

    always_ff @(posedge clk or posedge hw_rst) begin
        if (hw_rst) begin
            sw_cnt <= '0;
        end else if (sw_or_hw_rst) begin
            if (sw_cnt != '1) sw_cnt <= sw_cnt + 1'b1;
        end else begin
            sw_cnt <= '0;
        end
    end

    always_ff @(posedge clk or posedge por_rst) begin
        if (por_rst) begin
            since_por <= '0;
        end else begin
            since_por <= {since_por[0], 1'b1};
        end
    end

    // R1: power-on reset implies every other qualifier
    always @(negedge clk) begin
        if (por_rst === 1'b1) begin
            assert_por_nests_R1: assert (hw_rst && sw_or_hw_rst && !reset2_irq);
        end
    end

    assert_hw_nests_R2: assert property (@(posedge clk) disable iff (!por_n)
        hw_rst |-> sw_or_hw_rst);

    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (hw_rst)
        sw_or_hw_rst |-> (sw_cnt < PW'(PULSE_LEN)));

    assert_busy_fall_R4: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(cfg_rdata[1]) && !hw_rst) |-> !sw_or_hw_rst);

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (por_rst)
        (reset2_irq && !(cfg_wr && cfg_wdata[4])) |=> reset2_irq);

    assert_strap_hold_R8: assert property (@(posedge clk) disable iff (por_rst)
        (&since_por) |-> $stable(strap_q));
endmodule

bind host_rst_ctrl host_rst_ctrl_chk #(
    .PULSE_LEN (SW_PULSE_LEN),
    .STRAP_W   (STRAP_W),
    .CFG_W     (CFG_W)
) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .hw_rst       (hw_rst),
    .sw_or_hw_rst (sw_or_hw_rst),
    .por_rst      (por_rst),
    .reset2_irq   (reset2_irq),
    .strap_q      (strap_q)
);

// File: tb/host_rst_ctrl_tb.sv
`timescale 1ns/1ps
module host_rst_ctrl_tb;
    localparam int STRAP_W = 4;
    localparam int CFG_W   = 8;
    localparam int NVEC    = 8;

    // {prot_sel, pin_a, pin_b, exp_hw_rst, exp_gpio}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b00_00_0_0,
        6'b11_00_0_0,
        6'b01_10_0_1,
        6'b01_01_1_0,
        6'b10_01_0_1,
        6'b10_10_1_0,
        6'b01_11_0_1,
        6'b10_11_0_1
    };

    logic               clk = 1'b0;
    logic               por_n = 1'b0;
    logic               prim_rst_n = 1'b1;
    logic               alt_pin_a = 1'b1;
    logic               alt_pin_b = 1'b1;
    logic [1:0]         prot_sel = 2'b00;
    logic [STRAP_W-1:0] strap_in = 4'hA;
    logic               cfg_wr = 1'b0;
    logic [CFG_W-1:0]   cfg_wdata = '0;
    logic [CFG_W-1:0]   cfg_rdata;
    logic               hw_rst, sw_or_hw_rst, por_rst, reset2_irq, sec_gpio;
    logic [STRAP_W-1:0] strap_q;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    host_rst_ctrl u_dut (
        .clk(clk), .por_n(por_n), .prim_rst_n(prim_rst_n),
        .alt_pin_a(alt_pin_a), .alt_pin_b(alt_pin_b), .prot_sel(prot_sel),
        .strap_in(strap_in), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .hw_rst(hw_rst), .sw_or_hw_rst(sw_or_hw_rst),
        .por_rst(por_rst), .reset2_irq(reset2_irq), .sec_gpio(sec_gpio),
        .strap_q(strap_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [CFG_W-1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cycles(3);
        #1;
        chk("R1 por_rst", por_rst, 1);
        chk("R1 hw_rst", hw_rst, 1);
        chk("R1 sw_or_hw_rst", sw_or_hw_rst, 1);
        chk("R1 irq", reset2_irq, 0);
        chk("R1 strap", strap_q, 0);

        @(negedge clk); por_n = 1'b1;
        cycles(5);
        strap_in = 4'h5;
        #1;
        chk("R8 strap captured", strap_q, 4'hA);
        chk("R1 released hw", hw_rst, 0);
        chk("R1 released sw", sw_or_hw_rst, 0);

        // R2: asynchronous assertion, two-stage release
        @(negedge clk); #1; prim_rst_n = 1'b0; #1;
        chk("R2 async hw", hw_rst, 1);
        chk("R2 async sw", sw_or_hw_rst, 1);
        chk("R2 por stays", por_rst, 0);
        @(negedge clk); prim_rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R2 still held", hw_rst, 1);
        @(negedge clk); #1;
        chk("R2 released", hw_rst, 0);
        chk("R2 released sw", sw_or_hw_rst, 0);

        // R3/R4: single write, 4-cycle pulse
        cfg_write(8'h02);
        for (int i = 0; i < 6; i++) begin
            #1;
            chk("R3 pulse", sw_or_hw_rst, (i < 4) ? 1 : 0);
            chk("R4 busy", cfg_rdata[1], (i < 4) ? 1 : 0);
            chk("R3 hw quiet", hw_rst, 0);
            @(negedge clk);
        end

        // R5: writes held for three edges
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 8'h02;
        cycles(3);
        cfg_wr = 1'b0; cfg_wdata = '0;
        #1; chk("R5 pulse k+2", sw_or_hw_rst, 1);
        @(negedge clk); #1; chk("R5 pulse k+3", sw_or_hw_rst, 1);
        @(negedge clk); #1; chk("R5 pulse ends", sw_or_hw_rst, 0);

        // R10: hardware reset cancels a pulse
        cfg_write(8'h02);
        #1; prim_rst_n = 1'b0;
        @(negedge clk); prim_rst_n = 1'b1;
        cycles(4); #1;
        chk("R10 no pulse", sw_or_hw_rst, 0);
        chk("R10 busy clear", cfg_rdata[1], 0);
        chk("R8 strap after resets", strap_q, 4'hA);

        // R6/R9: secondary pin routing table
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            prot_sel  = VEC[v][5:4];
            alt_pin_a = VEC[v][3];
            alt_pin_b = VEC[v][2];
            cycles(4); #1;
            chk($sformatf("R6 vec%0d hw", v), hw_rst, VEC[v][1]);
            chk($sformatf("R9 vec%0d gpio", v), sec_gpio, VEC[v][0]);
        end

        // R7: sticky interrupt
        chk("R7 irq set", reset2_irq, 1);
        chk("R7 irq readback", cfg_rdata[4], 1);
        @(negedge clk); prim_rst_n = 1'b0;
        @(negedge clk); prim_rst_n = 1'b1;
        cycles(4);
        cfg_write(8'h02);
        cycles(6); #1;
        chk("R7 irq survives warm resets", reset2_irq, 1);
        cfg_write(8'h10); #1;
        chk("R7 irq cleared", reset2_irq, 0);
        chk("R7 no pulse from clear", sw_or_hw_rst, 0);

        prot_sel = 2'b01; alt_pin_a = 1'b0;
        cycles(5); alt_pin_a = 1'b1;
        cycles(5); #1;
        chk("R7 irq set again", reset2_irq, 1);

        // POR clears everything, strap re-latched
        @(negedge clk); por_n = 1'b0; strap_in = 4'h3; #1;
        chk("R1 por irq clear", reset2_irq, 0);
        chk("R1 por strap clear", strap_q, 0);
        @(negedge clk); por_n = 1'b1;
        cycles(5); strap_in = 4'hC; #1;
        chk("R8 strap relatched", strap_q, 4'h3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule